// File: doc/BRIEF.md
# Four-Way Set-Associative Read/Write Cache

This block sits between a processor and a word-wide memory port and keeps recently used words close by. It is organised as 256 sets of four ways, and each way holds a single 32-bit word together with a valid flag and a stored tag. For a byte address, bits [9:2] select a set and bits [31:10] form the tag. The two low bits pick a byte within the word and have no part in the lookup. All four ways of the selected set are compared at the same time. The comparator hits then drive a four-to-one select that returns the data.

A read that hits completes in the same cycle. A read that misses raises a memory read for the word address. When the memory acknowledges, the returned word is written into a way of the set and also passed to the processor. The way that receives the word is the lowest-numbered invalid way if the set has one; otherwise a three-bit tree pseudo-LRU entry kept for each set chooses it. Writes go through to memory. A write hit also updates the cached word, and a write miss leaves the cache unchanged. The processor holds its request stable until it sees ready. If read and write strobes are raised together, the write is taken.

Top module: `sa4_cache`

## Requirements
- R1: Bits [9:2] of the byte address select the set and bits [31:10] are the compared tag. An access that differs only in bits [1:0] hits the same word. An access that differs in the set or in the tag does not hit it.
- R2: A read hit raises cpu_ready in the same cycle as the request, does not raise mem_req, and returns the word stored in the matching way.
- R3: A read miss raises a memory read (mem_we = 0) at the word address. cpu_ready rises in the cycle of mem_ack, with cpu_rdata equal to mem_rdata. The word is then cached, so the next read of that address hits.
- R4: Reset clears every valid flag. The first read of any address after reset misses, even one that was cached before the reset.
- R5: Four words with distinct tags in one set are all resident at once, and each one returns its own data on a hit.
- R6: When all four ways of a set are valid, the victim follows a three-bit tree pseudo-LRU. Every hit or refill of a way points the tree away from that way. After ways 0 to 3 are filled in order, a fifth tag replaces way 0. If way 0 was read after those fills, the fifth tag replaces way 2 instead.
- R7: A write hit issues a memory write (mem_we = 1) with cpu_wdata, raises cpu_ready on mem_ack, and updates the cached word, so a later read hits with the new value and needs no memory read.
- R8: A write miss writes memory only and allocates nothing, so a later read of that address misses and returns the written value from memory.
- R9: While a memory operation is outstanding, cpu_ready stays low and mem_req stays high until mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cpu_addr | input | 32 | Processor byte address, held until cpu_ready |
| cpu_wdata | input | 32 | Processor write word |
| cpu_rd | input | 1 | Read request |
| cpu_wr | input | 1 | Write request (takes precedence over cpu_rd) |
| cpu_rdata | output | 32 | Read word, valid while cpu_ready is high on a read |
| cpu_ready | output | 1 | Access completes in this cycle |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a memory write, 0 for a refill read |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write word |
| mem_rdata | input | 32 | Memory read word, valid with mem_ack |
| mem_ack | input | 1 | One-cycle acknowledge from memory |

## Verification
The bench targets the replacement corners. It fills one set with four tags and then adds a fifth, once with no touch in between and once after re-reading way 0. A design whose tree bits are updated backwards, or only on refills, would evict the wrong resident, and a later hit would become a miss. It also checks that a stale tag left in storage after a reset does not produce a hit. It checks that a write miss does not allocate, which would show up as a hit with no memory read where a miss is required. Finally, it checks that the byte offset is kept out of the compare, and that a write hit updates the cached word, since a cache that skipped the update would return the old value on the next read.

// File: rtl/sa4_cache_pkg.sv
package sa4_cache_pkg;

  localparam int unsigned NWAYS = 4;

  typedef logic [1:0] way_idx_t;
  typedef logic [2:0] plru_t;   // [0]: half, [1]: pair of ways 0/1, [2]: pair of ways 2/3

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FILL  = 2'd1,
    ST_WTHRU = 2'd2
  } ctl_state_e;

  function automatic way_idx_t onehot_to_idx(input logic [NWAYS-1:0] oh);
    way_idx_t r;
    r = '0;
    for (int i = 0; i < NWAYS; i++) begin
      if (oh[i]) r = way_idx_t'(i);
    end
    return r;
  endfunction

  function automatic way_idx_t first_free(input logic [NWAYS-1:0] vld);
    way_idx_t r;
    r = '0;
    for (int i = NWAYS - 1; i >= 0; i--) begin
      if (!vld[i]) r = way_idx_t'(i);
    end
    return r;
  endfunction

  // Point the tree away from the way just used.
  function automatic plru_t plru_touch(input plru_t cur, input way_idx_t w);
    plru_t n;
    n = cur;
    if (!w[1]) begin
      n[0] = 1'b1;
      n[1] = ~w[0];
    end else begin
      n[0] = 1'b0;
      n[2] = ~w[0];
    end
    return n;
  endfunction

  function automatic way_idx_t plru_pick(input plru_t b);
    return b[0] ? {1'b1, b[2]} : {1'b0, b[1]};
  endfunction

endpackage

// File: rtl/sa4_way.sv
module sa4_way #(
  parameter int unsigned SET_W  = 8,
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SET_W-1:0]  set_idx,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              hit,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);

  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]   valid_q, valid_d;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [DATA_W-1:0] data_mem [SETS];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[set_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_mem[set_idx]  <= tag_in;
      data_mem[set_idx] <= wdata;
    end else if (upd_en) begin
      data_mem[set_idx] <= wdata;
    end
  end

  assign valid_o = valid_q[set_idx];
  assign hit     = valid_o && (tag_mem[set_idx] == tag_in);
  assign data_o  = data_mem[set_idx];

  // R7
  upd_on_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_en |-> hit);

  // R3
  fill_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |-> !hit);

endmodule

// File: rtl/sa4_plru.sv
module sa4_plru
  import sa4_cache_pkg::*;
#(
  parameter int unsigned SET_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_idx,
  input  logic [NWAYS-1:0] valid_set,
  input  logic             touch_en,
  input  way_idx_t         touch_way,
  output way_idx_t         victim
);

  localparam int unsigned SETS = 1 << SET_W;

  plru_t bits_q [SETS];
  plru_t entry_cur, entry_next;

  always_comb begin
    entry_cur  = bits_q[set_idx];
    entry_next = plru_touch(entry_cur, touch_way);
    victim     = (&valid_set) ? plru_pick(entry_cur) : first_free(valid_set);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) bits_q[s] <= '0;
    end else if (touch_en) begin
      bits_q[set_idx] <= entry_next;
    end
  end

  // R6
  victim_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(&valid_set) |-> !valid_set[victim]);

  // R6
  victim_not_recent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (touch_en && (&valid_set)) |=>
      ((set_idx != $past(set_idx)) || !(&valid_set) || (victim != $past(touch_way))));

endmodule

// File: rtl/sa4_ctrl.sv
module sa4_ctrl
  import sa4_cache_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_rd,
  input  logic req_wr,
  input  logic any_hit,
  input  logic mem_ack,
  output logic mem_req,
  output logic mem_we,
  output logic ready,
  output logic fill_en,
  output logic upd_en,
  output logic touch_en,
  output logic from_mem
);

  ctl_state_e state_q, state_d;
  logic       rd_op;

  assign rd_op = req_rd && !req_wr;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (req_wr)                 state_d = ST_WTHRU;
        else if (rd_op && !any_hit) state_d = ST_FILL;
      end
      ST_FILL:  if (mem_ack) state_d = ST_IDLE;
      ST_WTHRU: if (mem_ack) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    mem_req  = (state_q != ST_IDLE);
    mem_we   = (state_q == ST_WTHRU);
    from_mem = (state_q == ST_FILL);
    fill_en  = (state_q == ST_FILL) && mem_ack;
    upd_en   = (state_q == ST_WTHRU) && mem_ack && any_hit;
    ready    = ((state_q == ST_IDLE) && rd_op && any_hit) ||
               ((state_q != ST_IDLE) && mem_ack);
    touch_en = ((state_q == ST_IDLE) && rd_op && any_hit) || fill_en || upd_en;
  end

  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req);

  // R9
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |-> !ready);

endmodule

// File: rtl/sa4_cache.sv
module sa4_cache
  import sa4_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned SET_W  = 8,
  parameter int unsigned OFF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  input  logic              cpu_rd,
  input  logic              cpu_wr,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              cpu_ready,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              mem_ack
);

  localparam int unsigned TAG_W = ADDR_W - SET_W - OFF_W;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_sync_q;
  logic       rst_n_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  // Address fields
  logic [SET_W-1:0] set_idx;
  logic [TAG_W-1:0] tag_in;
  logic             addr_unused;

  assign set_idx     = cpu_addr[OFF_W +: SET_W];
  assign tag_in      = cpu_addr[ADDR_W-1 -: TAG_W];
  assign addr_unused = ^cpu_addr[OFF_W-1:0];

  // Control
  logic fill_en, upd_en, touch_en, from_mem, any_hit;

  // Ways
  logic [NWAYS-1:0]  hit_vec, valid_vec;
  logic [DATA_W-1:0] way_data [NWAYS];
  logic [DATA_W-1:0] way_wdata;
  way_idx_t          victim, hit_way, touch_way;

  assign way_wdata = from_mem ? mem_rdata : cpu_wdata;

  for (genvar g = 0; g < NWAYS; g++) begin : g_way
    logic way_fill, way_upd;
    assign way_fill = fill_en && (victim == way_idx_t'(g));
    assign way_upd  = upd_en && hit_vec[g];

    sa4_way #(
      .SET_W (SET_W),
      .TAG_W (TAG_W),
      .DATA_W(DATA_W)
    ) u_way (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .set_idx(set_idx),
      .tag_in (tag_in),
      .fill_en(way_fill),
      .upd_en (way_upd),
      .wdata  (way_wdata),
      .hit    (hit_vec[g]),
      .valid_o(valid_vec[g]),
      .data_o (way_data[g])
    );
  end

  assign any_hit   = |hit_vec;
  assign hit_way   = onehot_to_idx(hit_vec);
  assign touch_way = fill_en ? victim : hit_way;

  // Four-to-one select driven by the comparator hits
  logic [DATA_W-1:0] sel_data;
  always_comb begin
    sel_data = '0;
    for (int i = 0; i < NWAYS; i++) begin
      if (hit_vec[i]) sel_data = sel_data | way_data[i];
    end
  end

  sa4_plru #(.SET_W(SET_W)) u_plru (
    .clk      (clk),
    .rst_n    (rst_n_int),
    .set_idx  (set_idx),
    .valid_set(valid_vec),
    .touch_en (touch_en),
    .touch_way(touch_way),
    .victim   (victim)
  );

  sa4_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .req_rd  (cpu_rd),
    .req_wr  (cpu_wr),
    .any_hit (any_hit),
    .mem_ack (mem_ack),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .ready   (cpu_ready),
    .fill_en (fill_en),
    .upd_en  (upd_en),
    .touch_en(touch_en),
    .from_mem(from_mem)
  );

  assign cpu_rdata = from_mem ? mem_rdata : sel_data;
  assign mem_addr  = {cpu_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign mem_wdata = cpu_wdata;

  // R5
  hit_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    $onehot0(hit_vec));

  // R2
  hit_no_mem_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cpu_ready && !mem_ack) |-> !mem_req);

  // R3
  addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (mem_req && !mem_ack) |=> $stable(mem_addr));

endmodule

// File: tb/tb_sa4_cache.sv
`timescale 1ns/1ps
module tb_sa4_cache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic        cpu_rd = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [31:0] cpu_rdata;
  logic        cpu_ready;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  sa4_cache dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr),
    .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  // Memory model: fixed latency, one-cycle acknowledge
  logic [31:0]   store [4096];
  logic [4095:0] written = '0;
  int            lat_cnt = 0;
  int            rd_count = 0;

  function automatic logic [31:0] init_val(input logic [11:0] idx);
    return 32'h5A00_0000 ^ ({20'd0, idx} * 32'h0001_0011);
  endfunction

  function automatic logic [31:0] mem_val(input logic [31:0] a);
    return written[a[13:2]] ? store[a[13:2]] : init_val(a[13:2]);
  endfunction

  always @(posedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
    end else if (mem_req) begin
      if (lat_cnt == 2) begin
        lat_cnt <= 0;
        mem_ack <= 1'b1;
        if (mem_we) begin
          store[mem_addr[13:2]]   <= mem_wdata;
          written[mem_addr[13:2]] <= 1'b1;
        end else begin
          mem_rdata <= mem_val(mem_addr);
          rd_count  <= rd_count + 1;
        end
      end else begin
        lat_cnt <= lat_cnt + 1;
      end
    end
  end

  function automatic logic [31:0] mk(input int tag, input int set);
    return {tag[21:0], set[7:0], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [31:0] a, input logic [31:0] wd,
                        output int cyc, output logic [31:0] data, output int nrd,
                        output bit held);
    int r0;
    @(negedge clk);
    r0 = rd_count;
    cpu_addr = a; cpu_wdata = wd; cpu_wr = wr; cpu_rd = !wr;
    held = 1'b1; cyc = 0;
    #1;
    while (!cpu_ready && cyc < 60) begin
      @(posedge clk); #1;
      cyc++;
      if (!cpu_ready && cyc > 1 && !mem_req) held = 1'b0;
    end
    data = cpu_rdata;
    nrd  = rd_count - r0;
    @(negedge clk);
    cpu_rd = 1'b0; cpu_wr = 1'b0;
  endtask

  task automatic expect_hit(input logic [31:0] a, input logic [31:0] exp, input string req);
    int cyc, nrd; logic [31:0] d; bit held;
    access(1'b0, a, '0, cyc, d, nrd, held);
    chk(cyc == 0 && nrd == 0, req, "hit in request cycle", cyc, 0);
    chk(d == exp, req, "hit data", d, exp);
  endtask

  task automatic expect_miss(input logic [31:0] a, input logic [31:0] exp, input string req);
    int cyc, nrd; logic [31:0] d; bit held;
    access(1'b0, a, '0, cyc, d, nrd, held);
    chk(cyc > 0 && nrd == 1, req, "miss with one refill", nrd, 1);
    chk(d == exp, req, "refill data", d, exp);
    chk(held, "R9", "req held and ready low while busy", held, 1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    #1;
    chk(!cpu_ready, "R9", "ready low after reset", cpu_ready, 0);
    chk(!mem_req, "R9", "no mem request after reset", mem_req, 0);
    expect_miss(mk(0, 0), init_val(12'd0), "R4");
  endtask

  task automatic t_cold_then_hit();
    logic [31:0] a = mk(3, 7);
    expect_miss(a, mem_val(a), "R3");
    expect_hit(a, mem_val(a), "R2");
  endtask

  task automatic t_offset();
    logic [31:0] a = mk(3, 7);
    expect_hit(a + 32'd3, mem_val(a), "R1");
    expect_miss(mk(3, 8), mem_val(mk(3, 8)), "R1");
    expect_miss(mk(11, 7), mem_val(mk(11, 7)), "R1");
  endtask

  task automatic t_fill_four();
    for (int t = 1; t <= 4; t++) expect_miss(mk(t, 20), mem_val(mk(t, 20)), "R5");
    for (int t = 1; t <= 4; t++) expect_hit(mk(t, 20), mem_val(mk(t, 20)), "R5");
  endtask

  task automatic t_plru_plain();
    for (int t = 1; t <= 4; t++) expect_miss(mk(t, 5), mem_val(mk(t, 5)), "R6");
    expect_miss(mk(5, 5), mem_val(mk(5, 5)), "R6");
    expect_hit(mk(5, 5), mem_val(mk(5, 5)), "R6");
    expect_hit(mk(2, 5), mem_val(mk(2, 5)), "R6");
    expect_hit(mk(3, 5), mem_val(mk(3, 5)), "R6");
    expect_hit(mk(4, 5), mem_val(mk(4, 5)), "R6");
    expect_miss(mk(1, 5), mem_val(mk(1, 5)), "R6");
  endtask

  task automatic t_plru_touch();
    for (int t = 1; t <= 4; t++) expect_miss(mk(t, 9), mem_val(mk(t, 9)), "R6");
    expect_hit(mk(1, 9), mem_val(mk(1, 9)), "R6");
    expect_miss(mk(5, 9), mem_val(mk(5, 9)), "R6");
    expect_hit(mk(1, 9), mem_val(mk(1, 9)), "R6");
    expect_hit(mk(2, 9), mem_val(mk(2, 9)), "R6");
    expect_hit(mk(4, 9), mem_val(mk(4, 9)), "R6");
    expect_hit(mk(5, 9), mem_val(mk(5, 9)), "R6");
    expect_miss(mk(3, 9), mem_val(mk(3, 9)), "R6");
  endtask

  task automatic t_write_hit();
    int cyc, nrd; logic [31:0] d; bit held;
    logic [31:0] a = mk(3, 7);
    access(1'b1, a, 32'hDEAD_BEEF, cyc, d, nrd, held);
    chk(cyc > 0 && nrd == 0, "R7", "write waits for ack, no refill", nrd, 0);
    chk(held, "R9", "write req held", held, 1);
    chk(mem_val(a) == 32'hDEAD_BEEF, "R7", "memory written", mem_val(a), 32'hDEAD_BEEF);
    expect_hit(a, 32'hDEAD_BEEF, "R7");
  endtask

  task automatic t_write_miss();
    int cyc, nrd; logic [31:0] d; bit held;
    logic [31:0] a = mk(9, 40);
    access(1'b1, a, 32'h1234_5678, cyc, d, nrd, held);
    chk(cyc > 0 && nrd == 0, "R8", "write miss no refill", nrd, 0);
    chk(mem_val(a) == 32'h1234_5678, "R8", "memory written", mem_val(a), 32'h1234_5678);
    expect_miss(a, 32'h1234_5678, "R8");
  endtask

  task automatic t_reset_clears();
    do_reset();
    expect_miss(mk(3, 7), 32'hDEAD_BEEF, "R4");
    expect_miss(mk(1, 9), mem_val(mk(1, 9)), "R4");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_state();
    t_cold_then_hit();
    t_offset();
    t_fill_four();
    t_plru_plain();
    t_plru_touch();
    t_write_hit();
    t_write_miss();
    t_reset_clears();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule